// File: doc/BRIEF.md
# Reconfigurable Six-Input Lookup Cluster with Switch Matrix

This block is one logic cluster of a field-reconfigurable fabric. It holds sixteen six-input lookup cells. Each cell evaluates any Boolean function of its six inputs by reading a 64-entry, 1-bit truth table. The cells reach each other, the cluster inputs and the cluster outputs only through a single switch matrix. Horizontal lines carry the cluster inputs and the cell outputs. Vertical lines feed the cell inputs and the cluster outputs. At every junction sits a switch with its own configuration bit. A closed switch joins its horizontal line to its vertical line.

Configuration lives in a plane of its own, separate from the data path. A single configuration port picks one bit with a row address and a column address. Through that port it writes and reads switch bits, defect bits, truth table entries and the per-cell output register option. A defect bit marks a junction as faulty and keeps it open whatever its switch bit holds, so a working circuit can be laid out on the healthy junctions alone. Each cell output can be taken straight from the truth table or through a flip-flop, which lets registered pipelines be built. A vertical line driven by more than one closed junction raises an error flag.

Top module: `lut_cluster`

## Requirements
- R1: A cell output equals its truth table entry at index `{in5,...,in0}`, where cell input k (k = 0..5) is index bit k.
- R2: Horizontal rows 0..7 carry `data_i[7:0]` and rows 8..23 carry the outputs of cells 0..15. Vertical column `l*6+k` is input k of cell l. Column `96+o` is `data_o[o]`. Each vertical line is the OR of the rows joined to it by effective closed junctions, and it is 0 when there are none.
- R3: A junction whose defect bit is 1 is open whatever its switch bit holds, and a switch readback at that address returns 0. Clearing the defect bit restores the written switch value.
- R4: `multi_drv_o` is 1 exactly when at least one vertical line has two or more effective closed junctions.
- R5: `cfg_rdata_o` shows the addressed bit one clock after a cycle with `cfg_re_i` high, and it keeps its value while `cfg_re_i` stays low.
- R6: When the register option bit of a cell is 1, the cell output changes only at a rising clock edge, to the truth table value sampled at that edge. When the bit is 0, the output follows the inputs combinationally.
- R7: After reset all switch, defect, truth table and register option bits are 0. As a result, `data_o`, `multi_drv_o` and `cfg_rdata_o` are 0.
- R8: Writes to an address outside the target (row at or above 24 or column at or above 112 for switch and defect, row at or above 16 or column at or above 64 for truth tables, row at or above 16 for the register option) change nothing, and reads of such addresses return 0.
- R9: `cfg_sel_i` selects the target. 0 is the switch bit at (row, column). 1 is the defect bit at (row, column). 2 is truth table entry `column` of cell `row`. 3 is the register option of cell `row`, with the column ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_re_i | input | 1 | Configuration read strobe |
| cfg_sel_i | input | 2 | Configuration target select |
| cfg_row_i | input | 5 | Row address line select |
| cfg_col_i | input | 7 | Column address line select |
| cfg_wdata_i | input | 1 | Bit to write |
| cfg_rdata_o | output | 1 | Read-back bit, registered |
| data_i | input | 8 | Cluster data inputs |
| data_o | output | 16 | Cluster data outputs |
| multi_drv_o | output | 1 | Some vertical line has more than one driver |

## Verification
The assertions assume that the configuration strobes are only ever driven to 0 or 1 and that addresses are stable for the whole cycle in which a strobe is high. They also assume a cell with its register option clear never sits in a closed loop of unregistered cells. The stimulus writes configuration only between data checks and changes every input on the falling edge. It builds only acyclic routes, so each check samples a settled value. Multi-driver and defect cases are set up on purpose and then undone before the next pattern.

// File: rtl/lut_cluster_pkg.sv
package lut_cluster_pkg;
  typedef enum logic [1:0] {
    CFG_SWITCH = 2'd0,
    CFG_DEFECT = 2'd1,
    CFG_TRUTH  = 2'd2,
    CFG_REGOPT = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/xbar_cfg_plane.sv
module xbar_cfg_plane
  import lut_cluster_pkg::*;
#(
  parameter int N_ROW = 24,
  parameter int N_COL = 112,
  parameter int ROW_W = 5,
  parameter int COL_W = 7
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  cfg_sel_e                        sel_i,
  input  logic [ROW_W-1:0]                row_i,
  input  logic [COL_W-1:0]                col_i,
  input  logic                            wdata_i,
  output logic [N_ROW-1:0][N_COL-1:0]     closed_o,
  output logic                            sw_rd_o,
  output logic                            def_rd_o
);
  logic [N_ROW-1:0][N_COL-1:0] sw_q, def_q;
  logic in_range;

  assign in_range = ({1'b0, row_i} < (ROW_W+1)'(N_ROW)) &&
                    ({1'b0, col_i} < (COL_W+1)'(N_COL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= '0;
      def_q <= '0;
    end else if (we_i && in_range) begin
      if (sel_i == CFG_SWITCH) sw_q[row_i][col_i]  <= wdata_i;
      if (sel_i == CFG_DEFECT) def_q[row_i][col_i] <= wdata_i;
    end
  end

  // defect mask overrides the switch bit
  assign closed_o = sw_q & ~def_q;
  assign sw_rd_o  = in_range ? closed_o[row_i][col_i] : 1'b0;
  assign def_rd_o = in_range ? def_q[row_i][col_i] : 1'b0;

  // R9
  sw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_range && sel_i == CFG_SWITCH) |=>
      sw_q[$past(row_i)][$past(col_i)] == $past(wdata_i));
endmodule

// File: rtl/xbar_data_plane.sv
module xbar_data_plane #(
  parameter int N_ROW = 24,
  parameter int N_COL = 112
) (
  input  logic [N_ROW-1:0][N_COL-1:0] closed_i,
  input  logic [N_ROW-1:0]            row_i,
  output logic [N_COL-1:0]            col_o,
  output logic                        multi_o
);
  logic [N_COL-1:0] col_dup;

  for (genvar c = 0; c < N_COL; c++) begin : g_col
    always_comb begin
      logic seen;
      logic acc;
      seen       = 1'b0;
      acc        = 1'b0;
      col_dup[c] = 1'b0;
      for (int r = 0; r < N_ROW; r++) begin
        col_dup[c] = col_dup[c] | (seen & closed_i[r][c]);
        seen       = seen | closed_i[r][c];
        acc        = acc | (closed_i[r][c] & row_i[r]);
      end
      col_o[c] = acc;
    end
  end

  assign multi_o = |col_dup;
endmodule

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int K = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tbl_we_i,
  input  logic [K-1:0] tbl_idx_i,
  input  logic         tbl_d_i,
  input  logic         reg_we_i,
  input  logic         reg_d_i,
  input  logic [K-1:0] in_i,
  output logic         out_o,
  output logic         tbl_rd_o,
  output logic         reg_rd_o
);
  localparam int TBL = 2**K;

  logic [TBL-1:0] tbl_q;
  logic           reg_en_q;
  logic           eval;
  logic           out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q    <= '0;
      reg_en_q <= 1'b0;
    end else begin
      if (tbl_we_i) tbl_q[tbl_idx_i] <= tbl_d_i;
      if (reg_we_i) reg_en_q <= reg_d_i;
    end
  end

  assign eval = tbl_q[in_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= eval;
  end

  assign out_o    = reg_en_q ? out_q : eval;
  assign tbl_rd_o = tbl_q[tbl_idx_i];
  assign reg_rd_o = reg_en_q;

  // R1
  tbl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_i |=> tbl_q[$past(tbl_idx_i)] == $past(tbl_d_i));

  // R6
  reg_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_q && $past(reg_en_q)) |-> out_o == $past(eval));
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
  import lut_cluster_pkg::*;
#(
  parameter int N_LUT = 16,
  parameter int K     = 6,
  parameter int N_IN  = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   cfg_we_i,
  input  logic                                   cfg_re_i,
  input  logic [1:0]                             cfg_sel_i,
  input  logic [$clog2(N_IN+N_LUT)-1:0]          cfg_row_i,
  input  logic [$clog2(N_LUT*K+N_LUT)-1:0]       cfg_col_i,
  input  logic                                   cfg_wdata_i,
  output logic                                   cfg_rdata_o,
  input  logic [N_IN-1:0]                        data_i,
  output logic [N_LUT-1:0]                       data_o,
  output logic                                   multi_drv_o
);
  localparam int N_ROW = N_IN + N_LUT;
  localparam int N_COL = N_LUT * K + N_LUT;
  localparam int ROW_W = $clog2(N_ROW);
  localparam int COL_W = $clog2(N_COL);
  localparam int LUT_W = $clog2(N_LUT);
  localparam int TBL   = 2**K;

  cfg_sel_e                    sel;
  logic [N_ROW-1:0][N_COL-1:0] closed;
  logic [N_ROW-1:0]            rows;
  logic [N_COL-1:0]            cols;
  logic [N_LUT-1:0]            lut_out, lut_tbl_rd, lut_reg_rd;
  logic                        sw_rd, def_rd, lut_row_ok, tbl_col_ok, rd_next;

  assign sel        = cfg_sel_e'(cfg_sel_i);
  assign lut_row_ok = {1'b0, cfg_row_i} < (ROW_W+1)'(N_LUT);
  assign tbl_col_ok = {1'b0, cfg_col_i} < (COL_W+1)'(TBL);

  xbar_cfg_plane #(
    .N_ROW(N_ROW), .N_COL(N_COL), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (sel),
    .row_i   (cfg_row_i),
    .col_i   (cfg_col_i),
    .wdata_i (cfg_wdata_i),
    .closed_o(closed),
    .sw_rd_o (sw_rd),
    .def_rd_o(def_rd)
  );

  assign rows = {lut_out, data_i};

  xbar_data_plane #(.N_ROW(N_ROW), .N_COL(N_COL)) u_data (
    .closed_i(closed),
    .row_i   (rows),
    .col_o   (cols),
    .multi_o (multi_drv_o)
  );

  for (genvar l = 0; l < N_LUT; l++) begin : g_lut
    logic sel_me;
    assign sel_me = lut_row_ok && (cfg_row_i[LUT_W-1:0] == LUT_W'(l));
    lut_cell #(.K(K)) u_lut (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tbl_we_i (cfg_we_i && sel_me && sel == CFG_TRUTH && tbl_col_ok),
      .tbl_idx_i(cfg_col_i[K-1:0]),
      .tbl_d_i  (cfg_wdata_i),
      .reg_we_i (cfg_we_i && sel_me && sel == CFG_REGOPT),
      .reg_d_i  (cfg_wdata_i),
      .in_i     (cols[l*K +: K]),
      .out_o    (lut_out[l]),
      .tbl_rd_o (lut_tbl_rd[l]),
      .reg_rd_o (lut_reg_rd[l])
    );
  end

  assign data_o = cols[N_LUT*K +: N_LUT];

  always_comb begin
    unique case (sel)
      CFG_SWITCH: rd_next = sw_rd;
      CFG_DEFECT: rd_next = def_rd;
      CFG_TRUTH:  rd_next = (lut_row_ok && tbl_col_ok) ? lut_tbl_rd[cfg_row_i[LUT_W-1:0]] : 1'b0;
      default:    rd_next = lut_row_ok ? lut_reg_rd[cfg_row_i[LUT_W-1:0]] : 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_rdata_o <= 1'b0;
    else if (cfg_re_i) cfg_rdata_o <= rd_next;
  end

  // R3
  defect_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_re_i && sel == CFG_SWITCH && def_rd) |=> !cfg_rdata_o);

  // R5
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_re_i |=> $stable(cfg_rdata_o));
endmodule

// File: tb/sim_lut_cluster.sv
module sim_lut_cluster;
  localparam int ROW_W = 5;
  localparam int COL_W = 7;
  localparam logic [1:0] S_SW = 2'd0, S_DEF = 2'd1, S_TT = 2'd2, S_REG = 2'd3;
  // {data_i[2:0], expected {out2, p&q, p^q}}
  localparam logic [5:0] VEC [8] = '{6'b000_000, 6'b001_001, 6'b010_001, 6'b011_010,
                                     6'b100_100, 6'b101_101, 6'b110_101, 6'b111_110};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0, cfg_re = 1'b0, cfg_wdata = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [ROW_W-1:0] cfg_row = '0;
  logic [COL_W-1:0] cfg_col = '0;
  logic cfg_rdata, multi;
  logic [7:0] din = '0;
  logic [15:0] dout;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lut_cluster u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_re_i(cfg_re),
    .cfg_sel_i(cfg_sel), .cfg_row_i(cfg_row), .cfg_col_i(cfg_col),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .data_i(din),
    .data_o(dout), .multi_drv_o(multi)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input int r, input int c, input logic d);
    cfg_sel = s; cfg_row = ROW_W'(r); cfg_col = COL_W'(c); cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input int r, input int c, output logic v);
    cfg_sel = s; cfg_row = ROW_W'(r); cfg_col = COL_W'(c); cfg_re = 1'b1;
    @(negedge clk);
    cfg_re = 1'b0;
    v = cfg_rdata;
  endtask

  initial begin
    logic v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk("R7 data_o", dout, 16'h0);
    chk("R7 multi", {15'b0, multi}, 16'h0);
    chk("R7 rdata", {15'b0, cfg_rdata}, 16'h0);

    // cell 0 = xor, cell 1 = and of inputs 0 and 1 (R1)
    for (int i = 0; i < 64; i++) begin
      wr(S_TT, 0, i, i[0] ^ i[1]);
      wr(S_TT, 1, i, i[0] & i[1]);
    end
    // R2 routing: rows 0..7 data_i, row 8+l cell l; col l*6+k cell input; col 96+o output
    wr(S_SW, 0, 0, 1'b1);  wr(S_SW, 1, 1, 1'b1);
    wr(S_SW, 0, 6, 1'b1);  wr(S_SW, 1, 7, 1'b1);
    wr(S_SW, 8, 96, 1'b1); wr(S_SW, 9, 97, 1'b1);
    wr(S_SW, 2, 98, 1'b1);

    for (int i = 0; i < 8; i++) begin
      din = {5'b0, VEC[i][5:3]};
      @(negedge clk);
      chk("R1/R2 vector", dout, {13'b0, VEC[i][2:0]});
      chk("R4 single driver", {15'b0, multi}, 16'h0);
    end

    // R5 readback
    rd(S_SW, 0, 0, v);   chk("R5 switch read", {15'b0, v}, 16'h1);
    rd(S_TT, 0, 3, v);   chk("R5 truth read", {15'b0, v}, 16'h0);
    rd(S_TT, 1, 3, v);   chk("R9 truth read cell1", {15'b0, v}, 16'h1);
    rd(S_SW, 0, 0, v);
    wr(S_SW, 0, 0, 1'b0);
    chk("R5 rdata holds", {15'b0, cfg_rdata}, 16'h1);
    wr(S_SW, 0, 0, 1'b1);

    // R3 defect on junction (1,1)
    wr(S_DEF, 1, 1, 1'b1);
    din = 8'b011; @(negedge clk);
    chk("R3 defect opens", dout, 16'b010 | 16'b001);
    rd(S_SW, 1, 1, v);  chk("R3 switch reads 0", {15'b0, v}, 16'h0);
    rd(S_DEF, 1, 1, v); chk("R3 defect reads 1", {15'b0, v}, 16'h1);
    wr(S_DEF, 1, 1, 1'b0);
    @(negedge clk);
    chk("R3 restored", dout, 16'b010);

    // R4 multi-driver and OR of drivers on column 0
    wr(S_SW, 2, 0, 1'b1);
    din = 8'b100; @(negedge clk);
    chk("R4 multi set", {15'b0, multi}, 16'h1);
    chk("R2 or of drivers", dout, 16'b101);
    wr(S_SW, 2, 0, 1'b0);
    @(negedge clk);
    chk("R4 multi clear", {15'b0, multi}, 16'h0);

    // R6 registered option on cell 1
    wr(S_REG, 1, 0, 1'b1);
    rd(S_REG, 1, 0, v); chk("R9 regopt read", {15'b0, v}, 16'h1);
    din = 8'b000; @(negedge clk);
    din = 8'b011; #1;
    chk("R6 before edge", {15'b0, dout[1]}, 16'h0);
    @(negedge clk);
    chk("R6 after edge", {15'b0, dout[1]}, 16'h1);
    wr(S_REG, 1, 0, 1'b0);

    // R8 out-of-range
    wr(S_SW, 30, 0, 1'b1);
    rd(S_SW, 30, 0, v);  chk("R8 row oob read", {15'b0, v}, 16'h0);
    wr(S_SW, 8, 120, 1'b1);
    rd(S_SW, 8, 120, v); chk("R8 col oob read", {15'b0, v}, 16'h0);
    wr(S_TT, 20, 0, 1'b1);
    rd(S_TT, 20, 0, v);  chk("R8 truth oob read", {15'b0, v}, 16'h0);
    rd(S_REG, 20, 0, v); chk("R8 regopt oob read", {15'b0, v}, 16'h0);
    din = 8'b011; @(negedge clk);
    chk("R8 no side effect", dout, 16'b010);
    chk("R8 no multi", {15'b0, multi}, 16'h0);

    // R7 reset clears configuration
    rst_ni = 1'b0; @(negedge clk);
    rst_ni = 1'b1; @(negedge clk);
    chk("R7 data_o after reset", dout, 16'h0);
    rd(S_SW, 0, 0, v);  chk("R7 switch cleared", {15'b0, v}, 16'h0);
    rd(S_TT, 1, 3, v);  chk("R7 truth cleared", {15'b0, v}, 16'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule